// File: doc/BRIEF.md
# Code-Group Carrier Sense Detector

This block watches the receive stream of a 100 Mbit/s twisted-pair physical layer after descrambling, one 4B5B code bit per strobe of `bit_vld_i`. From that raw bit stream it derives a receive-carrier flag. It also reports the moment a start-of-stream delimiter is recognised, and it flags a false carrier when activity dies away before any delimiter arrives. Code-group alignment is unknown until the start delimiter has been seen. From then on the stream is cut into 5-bit groups on the boundary the delimiter fixed.

The controller has three states. `S_IDLE` means no carrier. `S_PRE` means carrier is present but no start delimiter has been seen yet. `S_FRAME` means the block is aligned and inside a stream. These are the transitions:
- *activate* (`S_IDLE`→`S_PRE`): a zero arrives with another zero two to nine bits earlier.
- *give-up* (`S_PRE`→`S_IDLE`): ten ones in a row arrive, and the false-carrier pulse fires.
- *lock* (`S_PRE`→`S_FRAME`): the ten newest bits equal the J/K pair, and the start flag pulses.
- *close* (`S_FRAME`→`S_IDLE`): an aligned T/R pair or an aligned IDLE/IDLE pair arrives.

An end pair is only known one group after its first symbol. For that reason the carrier output runs one code group (five valid bits) behind the internal state. On *close*, the delay line is flushed, so the carrier falls right after the T or the first IDLE.

Top module: `cs_carrier_sense`

## Requirements
- R1: After reset `carrier_o`, `ssd_o` and `false_car_o` are low, and the bit history is all ones, so a stream of ones never raises carrier.
- R2: In `S_IDLE`, carrier activates on a received 0 when another 0 lies 2 to 9 valid bits earlier. Two adjacent zeros do not activate it, and neither do zeros exactly 10 bits apart.
- R3: `carrier_o` follows the internal carrier five valid bits late. It is first high in the sample taken after the fifth valid bit that follows the activating bit.
- R4: In `S_PRE`, the tenth consecutive 1 returns the block to `S_IDLE`. `false_car_o` is high for exactly that one clock, and `carrier_o` is low from the fifth valid bit after it.
- R5: In `S_PRE`, when the ten newest bits, oldest first, equal J=11000 followed by K=10001 (each sent MSB first), `ssd_o` pulses for one clock. Code groups are then taken as every following 5 valid bits. A start delimiter is never recognised without prior carrier.
- R6: In `S_FRAME`, an aligned T=01101 directly followed by R=00111 ends carrier. `carrier_o` is still high in the sample after the last bit of R and low in the next one.
- R7: In `S_FRAME`, two aligned IDLE=11111 groups end carrier. `carrier_o` is still high in the sample after the last bit of the second IDLE and low in the next one.
- R8: A T followed by any group other than R, or an IDLE followed by any group other than IDLE, leaves carrier on.
- R9: A clock with `bit_vld_i` low changes no state and no `carrier_o` value. `ssd_o` and `false_car_o` are single-clock pulses even if the strobe is low next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit_i | input | 1 | Unscrambled receive code bit |
| bit_vld_i | input | 1 | Qualifies `rx_bit_i` for this clock |
| carrier_o | output | 1 | Receive carrier, one code group late |
| ssd_o | output | 1 | One-clock pulse when J/K is recognised |
| false_car_o | output | 1 | One-clock pulse when carrier ends without J/K |

## Verification
With a clean run of ones before J, the activating zero is the last bit of J. Five valid bits later is the last bit of K. So the delayed rise of `carrier_o` and the `ssd_o` pulse land in the same clock. Each frame test provokes this by sending ones, then J and K. It samples both outputs at that index and requires both high, with carrier low one bit earlier and the start pulse low one bit later. The same coincidence is repeated with a strobe gap right after K, to show that the pulse ends while the carrier holds.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int GRP_W = 5;

    localparam logic [GRP_W-1:0] CG_J    = 5'b11000;
    localparam logic [GRP_W-1:0] CG_K    = 5'b10001;
    localparam logic [GRP_W-1:0] CG_T    = 5'b01101;
    localparam logic [GRP_W-1:0] CG_R    = 5'b00111;
    localparam logic [GRP_W-1:0] CG_IDLE = 5'b11111;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PRE   = 2'd1,
        S_FRAME = 2'd2
    } cs_state_e;

endpackage

// File: rtl/cs_window.sv
module cs_window
    import cs_pkg::*;
#(
    parameter int WIN_BITS = 10,
    parameter int RUN_MAX  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic                bit_i,
    output logic [WIN_BITS-1:0] hist_o,
    output logic                trig_o,
    output logic                jk_o,
    output logic                run_full_o
);
    localparam int RUN_W = $clog2(RUN_MAX + 1);

    logic [WIN_BITS-1:0] hist_q;
    logic [RUN_W-1:0]    run_q;
    logic [WIN_BITS-1:0] win;

    // hist_q[i] is the bit received i+1 valid bits ago
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '1;
            run_q  <= '0;
        end else if (vld_i) begin
            hist_q <= {hist_q[WIN_BITS-2:0], bit_i};
            if (!bit_i)
                run_q <= '0;
            else if (run_q != RUN_W'(RUN_MAX))
                run_q <= run_q + 1'b1;
        end
    end

    always_comb begin
        win        = {hist_q[WIN_BITS-2:0], bit_i};
        trig_o     = !bit_i && (|(~hist_q[WIN_BITS-2:1]));
        jk_o       = (win[2*GRP_W-1:0] == {CG_J, CG_K});
        run_full_o = bit_i && (run_q >= RUN_W'(RUN_MAX - 1));
        hist_o     = hist_q;
    end

endmodule

// File: rtl/cs_group.sv
module cs_group
    import cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic             bit_i,
    input  logic [GRP_W-2:0] hist_lo_i,
    input  logic             align_i,
    input  logic             active_i,
    output logic             end_o
);
    localparam int PH_W = $clog2(GRP_W);

    logic [PH_W-1:0]  phase_q;
    logic             prev_t_q;
    logic             prev_idle_q;
    logic             complete;
    logic [GRP_W-1:0] grp;

    always_comb begin
        grp      = {hist_lo_i, bit_i};
        complete = active_i && (phase_q == PH_W'(GRP_W - 1));
        end_o    = complete && ((prev_t_q && grp == CG_R) ||
                                (prev_idle_q && grp == CG_IDLE));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= '0;
            prev_t_q    <= 1'b0;
            prev_idle_q <= 1'b0;
        end else if (vld_i) begin
            if (align_i || !active_i) begin
                phase_q     <= '0;
                prev_t_q    <= 1'b0;
                prev_idle_q <= 1'b0;
            end else begin
                phase_q <= complete ? '0 : phase_q + 1'b1;
                if (complete) begin
                    prev_t_q    <= !end_o && (grp == CG_T);
                    prev_idle_q <= !end_o && (grp == CG_IDLE);
                end
            end
        end
    end

    // R5
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        align_i && vld_i |=> phase_q == '0);

endmodule

// File: rtl/cs_delay.sv
module cs_delay #(
    parameter int DEPTH = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vld_i,
    input  logic d_i,
    input  logic flush_i,
    output logic q_o
);
    logic [DEPTH-1:0] dl_q;
    logic             q_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dl_q <= '0;
            q_q  <= 1'b0;
        end else if (vld_i) begin
            q_q  <= dl_q[DEPTH-1];
            dl_q <= flush_i ? '0 : {dl_q[DEPTH-2:0], d_i};
        end
    end

    assign q_o = q_q;

    // R6
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i && vld_i |=> dl_q == '0);

endmodule

// File: rtl/cs_carrier_sense.sv
module cs_carrier_sense
    import cs_pkg::*;
#(
    parameter int RUN_MAX  = 10,
    parameter int DLY_BITS = GRP_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit_i,
    input  logic bit_vld_i,
    output logic carrier_o,
    output logic ssd_o,
    output logic false_car_o
);
    localparam int WIN_BITS = 2 * GRP_W;

    cs_state_e           state_q, state_d;
    logic [WIN_BITS-1:0] hist;
    logic                trig, jk, run_full, frame_end;
    logic                raw_car, flush;
    logic                ssd_q, fc_q;

    cs_window #(.WIN_BITS(WIN_BITS), .RUN_MAX(RUN_MAX)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .vld_i      (bit_vld_i),
        .bit_i      (rx_bit_i),
        .hist_o     (hist),
        .trig_o     (trig),
        .jk_o       (jk),
        .run_full_o (run_full)
    );

    cs_group u_group (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_i     (bit_vld_i),
        .bit_i     (rx_bit_i),
        .hist_lo_i (hist[GRP_W-2:0]),
        .align_i   (state_q == S_PRE && jk),
        .active_i  (state_q == S_FRAME),
        .end_o     (frame_end)
    );

    always_comb begin
        state_d = state_q;
        if (bit_vld_i) begin
            unique case (state_q)
                S_IDLE:  if (trig)      state_d = S_PRE;
                S_PRE:   if (run_full)  state_d = S_IDLE;
                         else if (jk)   state_d = S_FRAME;
                S_FRAME: if (frame_end) state_d = S_IDLE;
                default:                state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssd_q <= 1'b0;
            fc_q  <= 1'b0;
        end else begin
            ssd_q <= bit_vld_i && state_q == S_PRE && jk && !run_full;
            fc_q  <= bit_vld_i && state_q == S_PRE && run_full;
        end
    end

    assign raw_car = (state_d != S_IDLE);
    assign flush   = (state_q == S_FRAME) && frame_end;

    cs_delay #(.DEPTH(DLY_BITS)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .vld_i   (bit_vld_i),
        .d_i     (raw_car),
        .flush_i (flush),
        .q_o     (carrier_o)
    );

    assign ssd_o       = ssd_q;
    assign false_car_o = fc_q;

    // R4
    fc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        false_car_o |=> !false_car_o);
    // R4
    fc_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        false_car_o |-> state_q == S_IDLE);
    // R5
    ssd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ssd_o |=> !ssd_o);
    // R5
    no_direct_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_IDLE |=> state_q != S_FRAME);
    // R3
    rise_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_o) |-> state_q != S_IDLE);
    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld_i |=> $stable(carrier_o) && $stable(state_q));

endmodule

// File: tb/cs_carrier_sense_tb.sv
module cs_carrier_sense_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b1;
    logic bit_vld = 1'b0;
    logic carrier, ssd, fc;

    int checks = 0;
    int fails = 0;
    int n = 0;
    logic car_log [0:511];
    logic ssd_log [0:511];
    logic fc_log  [0:511];

    localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                           R = 5'b00111, I = 5'b11111;
    localparam logic [4:0] D0 = 5'b11110, D1 = 5'b01001, D2 = 5'b10100,
                           D3 = 5'b10101;

    always #2 clk = ~clk;

    cs_carrier_sense u_dut (
        .clk(clk), .rst_n(rst_n), .rx_bit_i(rx_bit), .bit_vld_i(bit_vld),
        .carrier_o(carrier), .ssd_o(ssd), .false_car_o(fc)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_vld = 1'b0; rx_bit = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        n = 0;
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        rx_bit = b; bit_vld = 1'b1;
        @(posedge clk);
        #1;
        car_log[n] = carrier; ssd_log[n] = ssd; fc_log[n] = fc;
        n++;
    endtask

    task automatic send_grp(input logic [4:0] g);
        for (int i = 4; i >= 0; i--) send_bit(g[i]);
    endtask

    task automatic send_ones(input int cnt);
        for (int i = 0; i < cnt; i++) send_bit(1'b1);
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk(carrier, 1'b0, "R1 carrier after reset");
        chk(ssd, 1'b0, "R1 ssd after reset");
        chk(fc, 1'b0, "R1 false carrier after reset");
        send_ones(20);
        for (int i = 0; i < 20; i++) chk(car_log[i], 1'b0, "R1 ones stream no carrier");
    endtask

    task automatic t_frame_tr();
        int trg, kend, rend;
        do_reset();
        send_ones(10);
        send_grp(J); trg = n - 1;
        send_grp(K); kend = n - 1;
        send_grp(D0); send_grp(D1); send_grp(D2); send_grp(D3);
        send_grp(T); send_grp(R); rend = n - 1;
        send_ones(15);
        chk(car_log[trg+4], 1'b0, "R3 carrier not yet up");
        chk(car_log[trg+5], 1'b1, "R3 carrier up after one group");
        chk(ssd_log[kend], 1'b1, "R5 ssd at end of K");
        chk(ssd_log[kend-1], 1'b0, "R5 ssd not early");
        chk(ssd_log[kend+1], 1'b0, "R5 ssd one clock");
        chk(car_log[rend], 1'b1, "R6 carrier through T");
        chk(car_log[rend+1], 1'b0, "R6 carrier low after T");
        chk(car_log[rend+10], 1'b0, "R6 carrier stays low");
    endtask

    task automatic t_idle_end();
        int iend;
        do_reset();
        send_ones(10);
        send_grp(J); send_grp(K);
        send_grp(D1); send_grp(D2);
        send_grp(I); send_grp(I); iend = n - 1;
        send_ones(10);
        chk(car_log[iend], 1'b1, "R7 carrier through first IDLE");
        chk(car_log[iend+1], 1'b0, "R7 carrier low after first IDLE");
    endtask

    task automatic t_lone();
        int a, b, c;
        do_reset();
        send_ones(10);
        send_grp(J); send_grp(K);
        send_grp(T); send_grp(D1); a = n - 1;
        send_grp(I); send_grp(D2); b = n - 1;
        send_grp(T); send_grp(R); c = n - 1;
        send_ones(10);
        chk(car_log[a+1], 1'b1, "R8 lone T keeps carrier");
        chk(car_log[b+1], 1'b1, "R8 lone IDLE keeps carrier");
        chk(car_log[c], 1'b1, "R8 later T/R still ends: high at T");
        chk(car_log[c+1], 1'b0, "R8 later T/R still ends: low after T");
    endtask

    task automatic t_false();
        int trg, f;
        do_reset();
        send_ones(10);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); trg = n - 1;
        send_ones(10); f = n - 1;
        send_ones(8);
        chk(car_log[trg+5], 1'b1, "R4 carrier up before give-up");
        chk(fc_log[f-1], 1'b0, "R4 no false carrier at nine ones");
        chk(fc_log[f], 1'b1, "R4 false carrier at tenth one");
        chk(fc_log[f+1], 1'b0, "R4 false carrier one clock");
        chk(car_log[f+4], 1'b1, "R4 carrier still delayed high");
        chk(car_log[f+5], 1'b0, "R4 carrier low five bits later");
        for (int i = 0; i < n; i++) chk(ssd_log[i], 1'b0, "R5 no ssd without J/K");
    endtask

    task automatic t_window();
        int s, trg;
        do_reset();
        send_ones(10);
        s = n;
        send_bit(1'b0); send_bit(1'b0); send_ones(12);
        send_bit(1'b0); send_ones(9); send_bit(1'b0); send_ones(12);
        for (int i = s; i < n; i++) chk(car_log[i], 1'b0, "R2 adjacent or 10-apart zeros ignored");
        send_bit(1'b0); send_ones(8); send_bit(1'b0); trg = n - 1;
        send_ones(12);
        chk(car_log[trg+4], 1'b0, "R2 nine-apart zeros: not yet");
        chk(car_log[trg+5], 1'b1, "R2 nine-apart zeros activate");
    endtask

    task automatic t_gap();
        int kend, rend;
        do_reset();
        send_ones(10);
        send_grp(J); send_grp(K); kend = n - 1;
        chk(ssd_log[kend], 1'b1, "R5 ssd before gap");
        chk(car_log[kend], 1'b1, "R3 carrier rises with ssd");
        for (int g = 0; g < 6; g++) begin
            @(negedge clk);
            bit_vld = 1'b0; rx_bit = 1'b0;
            @(posedge clk);
            #1;
            chk(carrier, 1'b1, "R9 carrier holds in gap");
            chk(ssd, 1'b0, "R9 ssd pulse ends in gap");
        end
        send_grp(D3); send_grp(T); send_grp(R); rend = n - 1;
        send_ones(6);
        chk(car_log[rend], 1'b1, "R9 end position counts valid bits only");
        chk(car_log[rend+1], 1'b0, "R9 carrier drops after T post-gap");
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_frame_tr();
        t_idle_end();
        t_lone();
        t_false();
        t_window();
        t_gap();
        summary();
        $finish;
    end
endmodule